// File: doc/BRIEF.md
# Destination Forwarding Decision Unit

This unit decides where a frame goes, using its destination MAC address. When the address is unknown and the frame carries a memory-request header, the unit uses the header's 64-bit address-space id instead. A request strobe presents the destination MAC, the ingress port, a memory-header-valid flag and the address-space id. One cycle later, the unit returns a registered result. The result carries exactly one outcome: unicast to a port, flood to a multicast group, or drop.

A controller fills two exact-match tables through simple write ports. The first maps a MAC address to a port and can mark the address as a discard entry. The second maps an address-space id to a port and is fully associative. Each write either installs an entry at a given slot or invalidates that slot. When several valid slots match the same key, the lowest-numbered slot wins. Frame replication and queueing take place downstream.

Top module: `fwd_decide`

## Requirements
- R1: A request whose destination MAC hits a valid, non-discard MAC entry gives res_ucast=1, with res_port set to the stored port and res_grp=0, provided that port differs from the ingress port.
- R2: If a MAC hit's stored port equals the request's ingress port, the result is res_drop=1 (source pruning).
- R3: A MAC hit on an entry written with the discard bit set gives res_drop=1, whatever port is stored.
- R4: A MAC miss without a memory header gives res_flood=1 with res_grp=1.
- R5: A MAC miss with a memory header whose id hits a valid address-space entry gives res_ucast=1, with the stored port and res_grp=0. No source pruning is applied on this path.
- R6: A MAC miss with a memory header whose id matches no valid address-space entry gives res_drop=1.
- R7: All AS_N (default 64) address-space slots can be programmed and matched independently.
- R8: The result appears exactly one clock after the request: res_valid is high in the cycle after req_valid and low otherwise. When res_valid is high, exactly one of res_ucast, res_flood and res_drop is 1. When res_valid is low, all three are 0.
- R9: Writing a slot with the set bit at 0 invalidates it, so later requests for its key miss.
- R10: When several valid slots of one table hold the same key, the slot with the lowest index decides the outcome.
- R11: On a MAC hit, the memory-header flag and the id have no effect on the outcome.
- R12: While rst_n is low and after its release, all table slots are invalid and res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_dmac | input | 48 | Destination MAC address |
| req_in_port | input | PORT_W | Ingress port |
| req_mem_ok | input | 1 | Memory-request header present |
| req_asid | input | 64 | Address-space id |
| mac_we | input | 1 | MAC table write strobe |
| mac_idx | input | $clog2(MAC_N) | MAC table slot |
| mac_set | input | 1 | 1 installs the slot, 0 invalidates it |
| mac_key | input | 48 | MAC address to store |
| mac_port | input | PORT_W | Port to store |
| mac_discard | input | 1 | Marks the entry as a discard entry |
| as_we | input | 1 | Address-space table write strobe |
| as_idx | input | $clog2(AS_N) | Address-space slot |
| as_set | input | 1 | 1 installs the slot, 0 invalidates it |
| as_key | input | 64 | Address-space id to store |
| as_port | input | PORT_W | Port to store |
| res_valid | output | 1 | Result strobe |
| res_ucast | output | 1 | Unicast outcome |
| res_port | output | PORT_W | Unicast egress port |
| res_flood | output | 1 | Flood outcome |
| res_grp | output | GRP_W | Multicast group |
| res_drop | output | 1 | Drop outcome |

## Verification
On every cycle, the assertions check the timing of the strobes and that exactly one outcome is set. They also check that a flood always carries group 1, that any non-flood result carries group 0, and that a unicast back to the ingress port only happens on the memory path. Only the bench's scenarios can show the choice of port. That covers pruning against a real hit, discard entries, invalidation, lowest-slot priority among duplicates, the full population of the address-space table, and the fact that the memory header is ignored on a MAC hit.

// File: rtl/fwd_decide.sv
module fwd_decide #(
  parameter int PORT_W = 9,
  parameter int GRP_W  = 16,
  parameter int MAC_N  = 16,
  parameter int AS_N   = 64,
  localparam int MI_W  = $clog2(MAC_N),
  localparam int AI_W  = $clog2(AS_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [47:0]       req_dmac,
  input  logic [PORT_W-1:0] req_in_port,
  input  logic              req_mem_ok,
  input  logic [63:0]       req_asid,
  input  logic              mac_we,
  input  logic [MI_W-1:0]   mac_idx,
  input  logic              mac_set,
  input  logic [47:0]       mac_key,
  input  logic [PORT_W-1:0] mac_port,
  input  logic              mac_discard,
  input  logic              as_we,
  input  logic [AI_W-1:0]   as_idx,
  input  logic              as_set,
  input  logic [63:0]       as_key,
  input  logic [PORT_W-1:0] as_port,
  output logic              res_valid,
  output logic              res_ucast,
  output logic [PORT_W-1:0] res_port,
  output logic              res_flood,
  output logic [GRP_W-1:0]  res_grp,
  output logic              res_drop
);
  logic [MAC_N-1:0]  mv;
  logic [47:0]       mk [MAC_N];
  logic [PORT_W-1:0] mp [MAC_N];
  logic [MAC_N-1:0]  md;
  logic [AS_N-1:0]   av;
  logic [63:0]       ak [AS_N];
  logic [PORT_W-1:0] ap [AS_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mv <= '0;
      av <= '0;
    end else begin
      if (mac_we) mv[mac_idx] <= mac_set;
      if (as_we)  av[as_idx]  <= as_set;
    end
  end

  always_ff @(posedge clk) begin
    if (mac_we && mac_set) begin
      mk[mac_idx] <= mac_key;
      mp[mac_idx] <= mac_port;
      md[mac_idx] <= mac_discard;
    end
    if (as_we && as_set) begin
      ak[as_idx] <= as_key;
      ap[as_idx] <= as_port;
    end
  end

  logic [MAC_N-1:0] mac_m;
  logic [AS_N-1:0]  as_m;
  for (genvar i = 0; i < MAC_N; i++) begin : g_mac
    assign mac_m[i] = mv[i] && (mk[i] == req_dmac);
  end
  for (genvar j = 0; j < AS_N; j++) begin : g_as
    assign as_m[j] = av[j] && (ak[j] == req_asid);
  end

  logic              m_hit, m_disc, a_hit;
  logic [PORT_W-1:0] m_port, a_port;
  always_comb begin
    m_hit = 1'b0; m_disc = 1'b0; m_port = '0;
    for (int i = MAC_N-1; i >= 0; i--)
      if (mac_m[i]) begin
        m_hit = 1'b1; m_disc = md[i]; m_port = mp[i];
      end
    a_hit = 1'b0; a_port = '0;
    for (int j = AS_N-1; j >= 0; j--)
      if (as_m[j]) begin
        a_hit = 1'b1; a_port = ap[j];
      end
  end

  logic              n_uc, n_fl, n_dr;
  logic [PORT_W-1:0] n_port;
  always_comb begin
    n_uc = 1'b0; n_fl = 1'b0; n_dr = 1'b0; n_port = '0;
    if (m_hit) begin
      if (m_disc || m_port == req_in_port) n_dr = 1'b1;
      else begin n_uc = 1'b1; n_port = m_port; end
    end else if (req_mem_ok) begin
      if (a_hit) begin n_uc = 1'b1; n_port = a_port; end
      else n_dr = 1'b1;
    end else n_fl = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0; res_ucast <= 1'b0; res_flood <= 1'b0;
      res_drop <= 1'b0; res_port <= '0; res_grp <= '0;
    end else begin
      res_valid <= req_valid;
      res_ucast <= req_valid & n_uc;
      res_flood <= req_valid & n_fl;
      res_drop  <= req_valid & n_dr;
      res_port  <= req_valid ? n_port : '0;
      res_grp   <= GRP_W'(req_valid & n_fl);
    end
  end
endmodule

// File: rtl/fwd_decide_chk.sv
module fwd_decide_chk #(
  parameter int PORT_W = 9,
  parameter int GRP_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [PORT_W-1:0] req_in_port,
  input logic              req_mem_ok,
  input logic              res_valid,
  input logic              res_ucast,
  input logic [PORT_W-1:0] res_port,
  input logic              res_flood,
  input logic [GRP_W-1:0]  res_grp,
  input logic              res_drop
);
  // R8
  lat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> res_valid);
  // R8
  lat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !res_valid);
  // R8
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones({res_ucast, res_flood, res_drop}) == 1);
  // R8
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !(res_ucast || res_flood || res_drop));
  // R4
  flood_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_flood |-> res_grp == GRP_W'(1));
  // R5
  grp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_flood) |-> res_grp == '0);
  // R2
  prune_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid ##1 (res_ucast && res_port == $past(req_in_port)) |-> $past(req_mem_ok));
endmodule

bind fwd_decide fwd_decide_chk #(.PORT_W(PORT_W), .GRP_W(GRP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_in_port(req_in_port),
  .req_mem_ok(req_mem_ok), .res_valid(res_valid), .res_ucast(res_ucast),
  .res_port(res_port), .res_flood(res_flood), .res_grp(res_grp), .res_drop(res_drop)
);

// File: tb/sim_fwd_decide.sv
`timescale 1ns/1ps
module sim_fwd_decide;
  localparam int PW = 9, GW = 16, MN = 16, AN = 64;
  localparam int EW = 3 + GW + PW;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_mem_ok = 0;
  logic [47:0] req_dmac = 0;
  logic [PW-1:0] req_in_port = 0;
  logic [63:0] req_asid = 0;
  logic mac_we = 0, mac_set = 0, mac_discard = 0;
  logic [3:0] mac_idx = 0;
  logic [47:0] mac_key = 0;
  logic [PW-1:0] mac_port = 0;
  logic as_we = 0, as_set = 0;
  logic [5:0] as_idx = 0;
  logic [63:0] as_key = 0;
  logic [PW-1:0] as_port = 0;
  logic res_valid, res_ucast, res_flood, res_drop;
  logic [PW-1:0] res_port;
  logic [GW-1:0] res_grp;

  fwd_decide u0 (.*);

  int checks = 0, errors = 0;
  logic [EW-1:0] expq[$];
  string tagq[$];

  logic bm_mv[MN]; logic [47:0] bm_mk[MN]; logic [PW-1:0] bm_mp[MN]; logic bm_md[MN];
  logic bm_av[AN]; logic [63:0] bm_ak[AN]; logic [PW-1:0] bm_ap[AN];

  function automatic logic [EW-1:0] model(logic [47:0] d, logic [PW-1:0] ip, logic mo, logic [63:0] id);
    for (int i = 0; i < MN; i++)
      if (bm_mv[i] && bm_mk[i] == d) begin
        if (bm_md[i] || bm_mp[i] == ip) return {3'b001, GW'(0), PW'(0)};
        return {3'b100, GW'(0), bm_mp[i]};
      end
    if (!mo) return {3'b010, GW'(1), PW'(0)};
    for (int j = 0; j < AN; j++)
      if (bm_av[j] && bm_ak[j] == id) return {3'b100, GW'(0), bm_ap[j]};
    return {3'b001, GW'(0), PW'(0)};
  endfunction

  task automatic send(logic [47:0] d, logic [PW-1:0] ip, logic mo, logic [63:0] id, string tag);
    @(negedge clk);
    req_valid = 1; req_dmac = d; req_in_port = ip; req_mem_ok = mo; req_asid = id;
    expq.push_back(model(d, ip, mo, id));
    tagq.push_back(tag);
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); req_valid = 0; end
  endtask

  task automatic wmac(int i, logic s, logic [47:0] k, logic [PW-1:0] p, logic dsc);
    @(negedge clk);
    req_valid = 0;
    mac_we = 1; mac_idx = 4'(i); mac_set = s; mac_key = k; mac_port = p; mac_discard = dsc;
    bm_mv[i] = s; if (s) begin bm_mk[i] = k; bm_mp[i] = p; bm_md[i] = dsc; end
    @(negedge clk); mac_we = 0;
  endtask

  task automatic was(int i, logic s, logic [63:0] k, logic [PW-1:0] p);
    @(negedge clk);
    req_valid = 0;
    as_we = 1; as_idx = 6'(i); as_set = s; as_key = k; as_port = p;
    bm_av[i] = s; if (s) begin bm_ak[i] = k; bm_ap[i] = p; end
    @(negedge clk); as_we = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R8: result without request, actual valid=1 expected valid=0");
        end else begin
          automatic logic [EW-1:0] e = expq.pop_front();
          automatic string t = tagq.pop_front();
          automatic logic [EW-1:0] a = {res_ucast, res_flood, res_drop, res_grp, res_port};
          if (a !== e) begin
            errors++;
            $display("FAIL %s: actual u/f/d=%b grp=%0d port=%0d expected u/f/d=%b grp=%0d port=%0d",
              t, a[EW-1 -: 3], a[PW +: GW], a[PW-1:0], e[EW-1 -: 3], e[PW +: GW], e[PW-1:0]);
          end
        end
      end else if (res_ucast || res_flood || res_drop) begin
        checks++; errors++;
        $display("FAIL R8: outcome set while idle, actual u/f/d=%b expected 000",
          {res_ucast, res_flood, res_drop});
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < MN; i++) bm_mv[i] = 0;
    for (int j = 0; j < AN; j++) bm_av[j] = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 0 || res_ucast !== 0 || res_flood !== 0 || res_drop !== 0) begin
      errors++; $display("FAIL R12: reset outputs actual v=%b expected 0", res_valid);
    end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (res_valid !== 0) begin errors++; $display("FAIL R12: actual valid=%b expected 0", res_valid); end
    send(48'hA, 1, 0, 0, "R12");
    idle(2);

    wmac(0, 1, 48'hA, 5, 0);
    wmac(1, 1, 48'hB, 3, 1);
    wmac(2, 1, 48'hC, 7, 0);
    wmac(3, 1, 48'hA, 9, 0);
    for (int j = 0; j < AN; j++) was(j, 1, 64'h1000 + 64'(j), PW'(j + 1));

    send(48'hA, 2, 0, 0, "R1");
    send(48'hA, 2, 0, 0, "R10");
    send(48'hA, 5, 0, 0, "R2");
    send(48'hB, 2, 0, 0, "R3");
    send(48'hB, 3, 1, 64'h1000, "R3");
    send(48'hC, 4, 0, 0, "R1");
    send(48'hD, 4, 0, 0, "R4");
    idle(1);
    send(48'hD, 4, 1, 64'h1000 + 63, "R7");
    send(48'hD, 4, 1, 64'h1000, "R7");
    send(48'hD, 8, 1, 64'h1007, "R5");
    send(48'hD, 2, 1, 64'h9999, "R6");
    send(48'hA, 2, 1, 64'h9999, "R11");
    send(48'hA, 2, 1, 64'h1003, "R11");
    idle(3);

    wmac(2, 0, 0, 0, 0);
    send(48'hC, 4, 0, 0, "R9");
    wmac(0, 0, 0, 0, 0);
    send(48'hA, 2, 0, 0, "R10");
    was(63, 0, 0, 0);
    send(48'hD, 4, 1, 64'h1000 + 63, "R9");
    was(10, 1, 64'h1000 + 20, 44);
    send(48'hD, 4, 1, 64'h1000 + 20, "R10");
    idle(4);

    checks++;
    if (expq.size() != 0) begin
      errors++; $display("FAIL R8: results missing actual=%0d expected 0", expq.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule